// File: doc/BRIEF.md
# RTC Update Cycle Sequencer

This block paces the once-per-second refresh of a real-time clock's time registers. A 1 Hz tick from the clock divider starts an update sequence. First the block raises an update-in-progress status flag (UIP) for a guard window. At the end of that window it issues a one-cycle strobe that tells the time counters to advance. The flag then stays high for the duration of the transfer. When the transfer is done, the flag drops and the block emits an update-ended pulse.

On that same final cycle, the block compares the seconds, minutes and hours counts against three alarm bytes. If all three fields match, it also emits an alarm pulse. An alarm byte whose two top bits are both set matches any value. Software can therefore read the time safely whenever UIP is 0.

A SET control bit stops updates and clears UIP. A divider-run input gates the whole sequence. When the divider starts, the first update follows after a half-second delay rather than waiting for the next tick. All timing windows are expressed in clock cycles through parameters: `LEAD_CYC` for the guard window, `XFER_CYC` for the transfer and `HALF_CYC` for the half-second start delay.

Top module: `rtc_update_seq`

## Requirements
- R1: After reset, uip_o, upd_stb_o, alarm_evt_o and uend_evt_o are all 0.
- R2: A tick accepted while idle sets uip_o from the next cycle on, and uip_o then stays high for exactly LEAD_CYC+XFER_CYC cycles. A tick is accepted when tick_i=1, set_i=0, div_run_i=1 and the block is armed.
- R3: upd_stb_o is high for exactly one cycle per update. That cycle is the (LEAD_CYC+1)th cycle of the uip_o window, so UIP has been high for LEAD_CYC cycles before the counters are told to advance.
- R4: uend_evt_o is a one-cycle pulse in the cycle right after the last uip_o cycle, and uip_o is 0 in that cycle.
- R5: alarm_evt_o is a one-cycle pulse coincident with uend_evt_o. It is 1 only when all three time inputs, sampled in the last uip_o cycle, match their alarm bytes. These are post-update values.
- R6: An alarm byte with bits [7:6] = 2'b11 matches any value of its time field. Any other alarm byte matches only on equality.
- R7: While set_i=1, no update starts. A set_i sampled high aborts a running sequence: uip_o is 0 in the next cycle, and no strobe or event pulse follows.
- R8: While div_run_i=0, ticks are ignored. A div_run_i sampled low aborts a running sequence, with uip_o 0 in the next cycle.
- R9: After div_run_i is first sampled high, the first update starts HALF_CYC edges later without a tick, with uip_o high from the following cycle. Ticks during that delay are ignored.
- R10: Ticks arriving while a sequence is running are ignored and do not lengthen or restart it.
- R11: The alarm pulse recurs on every completed update for as long as the match holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle 1 Hz tick from the divider |
| set_i | input | 1 | SET control bit; inhibits and aborts updates |
| div_run_i | input | 1 | Divider running indication |
| sec_i | input | DATA_W | Current seconds count |
| min_i | input | DATA_W | Current minutes count |
| hr_i | input | DATA_W | Current hours count |
| alm_sec_i | input | DATA_W | Seconds alarm byte |
| alm_min_i | input | DATA_W | Minutes alarm byte |
| alm_hr_i | input | DATA_W | Hours alarm byte |
| uip_o | output | 1 | Update-in-progress status |
| upd_stb_o | output | 1 | One-cycle strobe telling the time counters to advance |
| alarm_evt_o | output | 1 | One-cycle alarm-match event |
| uend_evt_o | output | 1 | One-cycle update-ended event |

## Verification
The design samples an accepted tick at a clock edge, and uip_o rises in the cycle after that edge. upd_stb_o follows LEAD_CYC cycles later, and uend_evt_o and alarm_evt_o follow LEAD_CYC+XFER_CYC cycles after the tick edge. An abort through set_i or div_run_i lowers uip_o one cycle after the edge at which it is sampled. The first update after div_run_i rises begins HALF_CYC edges after the rising edge is seen.

The bench drives every input on the falling edge and steps a behavioural phase model on the rising edge, using the same input values the design sees. It compares all four outputs at each following falling edge, so every due cycle is checked exactly. The bench also acts as the time counter: it advances seconds whenever it observes the strobe, which makes the alarm comparison see post-update values. Per-scenario pulse counts then check the ignore, abort and recurrence rules.

// File: rtl/rtc_upd_pkg.sv
package rtc_upd_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LEAD = 2'd1,
    PH_XFER = 2'd2
  } upd_phase_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned N_FIELDS = 3
) (
  input  logic [N_FIELDS*DATA_W-1:0] cur_i,
  input  logic [N_FIELDS*DATA_W-1:0] alm_i,
  output logic                       match_o
);

  logic [N_FIELDS-1:0] fld_hit;

  // Each field hits on equality or on a wildcard alarm byte (top two bits set).
  for (genvar g = 0; g < N_FIELDS; g++) begin : g_fld
    logic [DATA_W-1:0] cur_b;
    logic [DATA_W-1:0] alm_b;
    assign cur_b      = cur_i[g*DATA_W +: DATA_W];
    assign alm_b      = alm_i[g*DATA_W +: DATA_W];
    assign fld_hit[g] = (alm_b == cur_b) || (alm_b[DATA_W-1 -: 2] == 2'b11);
  end

  assign match_o = &fld_hit;

endmodule

// File: rtl/rtc_start_ctl.sv
module rtc_start_ctl #(
  parameter int unsigned HALF_CYC = 500000,
  localparam int unsigned HW      = $clog2(HALF_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic div_run_i,
  input  logic set_i,
  input  logic tick_i,
  output logic start_o
);

  logic          div_q,   div_d;
  logic          wait_q,  wait_d;
  logic          armed_q, armed_d;
  logic [HW-1:0] hcnt_q,  hcnt_d;
  logic          fire;

  always_comb begin
    div_d   = div_run_i;
    wait_d  = wait_q;
    armed_d = armed_q;
    hcnt_d  = hcnt_q;
    fire    = 1'b0;
    if (!div_run_i) begin
      wait_d  = 1'b0;
      armed_d = 1'b0;
      hcnt_d  = '0;
    end else if (!div_q) begin
      wait_d  = 1'b1;
      armed_d = 1'b0;
      hcnt_d  = '0;
    end else if (wait_q) begin
      if (hcnt_q == HW'(HALF_CYC - 1)) begin
        wait_d  = 1'b0;
        armed_d = 1'b1;
        fire    = 1'b1;
      end else begin
        hcnt_d = hcnt_q + 1'b1;
      end
    end
  end

  assign start_o = div_run_i & ~set_i & (fire | (armed_q & tick_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= 1'b0;
      wait_q  <= 1'b0;
      armed_q <= 1'b0;
      hcnt_q  <= '0;
    end else begin
      div_q   <= div_d;
      wait_q  <= wait_d;
      armed_q <= armed_d;
      hcnt_q  <= hcnt_d;
    end
  end

  // R9
  start_needs_settled_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> $past(div_run_i));

endmodule

// File: rtl/rtc_phase_cnt.sv
module rtc_phase_cnt #(
  parameter int unsigned MAX_CYC = 1984,
  localparam int unsigned PW     = $clog2(MAX_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic [PW-1:0] lim_i,
  output logic          last_o
);

  logic [PW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = clr_i ? '0 : cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == lim_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= lim_i);

endmodule

// File: rtl/rtc_update_seq.sv
module rtc_update_seq
  import rtc_upd_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned LEAD_CYC = 244,
  parameter int unsigned XFER_CYC = 1984,
  parameter int unsigned HALF_CYC = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              set_i,
  input  logic              div_run_i,
  input  logic [DATA_W-1:0] sec_i,
  input  logic [DATA_W-1:0] min_i,
  input  logic [DATA_W-1:0] hr_i,
  input  logic [DATA_W-1:0] alm_sec_i,
  input  logic [DATA_W-1:0] alm_min_i,
  input  logic [DATA_W-1:0] alm_hr_i,
  output logic              uip_o,
  output logic              upd_stb_o,
  output logic              alarm_evt_o,
  output logic              uend_evt_o
);

  localparam int unsigned N_FIELDS = 3;
  localparam int unsigned MAX_CYC  = max_u(LEAD_CYC, XFER_CYC);
  localparam int unsigned PW       = $clog2(MAX_CYC + 1);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rs_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_int = rs_q[1];

  logic start, last, match, abort, clr;
  logic [PW-1:0] lim;

  rtc_start_ctl #(.HALF_CYC(HALF_CYC)) u_start (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .div_run_i (div_run_i),
    .set_i     (set_i),
    .tick_i    (tick_i),
    .start_o   (start)
  );

  rtc_alarm_cmp #(.DATA_W(DATA_W), .N_FIELDS(N_FIELDS)) u_cmp (
    .cur_i   ({hr_i, min_i, sec_i}),
    .alm_i   ({alm_hr_i, alm_min_i, alm_sec_i}),
    .match_o (match)
  );

  upd_phase_e state_q, state_d;
  logic       stb_q, stb_d;
  logic       uend_q, uend_d;
  logic       alm_q, alm_d;

  assign abort = set_i | ~div_run_i;
  assign lim   = (state_q == PH_XFER) ? PW'(XFER_CYC - 1) : PW'(LEAD_CYC - 1);

  always_comb begin
    state_d = state_q;
    stb_d   = 1'b0;
    uend_d  = 1'b0;
    alm_d   = 1'b0;
    unique case (state_q)
      PH_IDLE: if (start) state_d = PH_LEAD;
      PH_LEAD: begin
        if (abort) state_d = PH_IDLE;
        else if (last) begin
          state_d = PH_XFER;
          stb_d   = 1'b1;
        end
      end
      PH_XFER: begin
        if (abort) state_d = PH_IDLE;
        else if (last) begin
          state_d = PH_IDLE;
          uend_d  = 1'b1;
          alm_d   = match;
        end
      end
      default: state_d = PH_IDLE;
    endcase
  end

  assign clr = (state_q == PH_IDLE) | (state_d != state_q);

  rtc_phase_cnt #(.MAX_CYC(MAX_CYC)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .clr_i  (clr),
    .lim_i  (lim),
    .last_o (last)
  );

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      state_q <= PH_IDLE;
      stb_q   <= 1'b0;
      uend_q  <= 1'b0;
      alm_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      stb_q   <= stb_d;
      uend_q  <= uend_d;
      alm_q   <= alm_d;
    end
  end

  assign uip_o       = (state_q != PH_IDLE);
  assign upd_stb_o   = stb_q;
  assign uend_evt_o  = uend_q;
  assign alarm_evt_o = alm_q;

  // R3
  stb_inside_uip_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    upd_stb_o |-> uip_o);

  // R4
  uend_after_uip_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    uend_evt_o |-> (!uip_o && $past(uip_o)));

  // R5
  alarm_with_uend_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    alarm_evt_o |-> uend_evt_o);

  // R7
  set_clears_uip_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    set_i |=> !uip_o);

  // R8
  divoff_clears_uip_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    !div_run_i |=> !uip_o);

endmodule

// File: tb/tb_rtc_update_seq.sv
module tb_rtc_update_seq;

  localparam int CLK_PERIOD = 10;
  localparam int DW   = 8;
  localparam int LEAD = 5;
  localparam int XFER = 12;
  localparam int HALF = 20;

  logic clk = 1'b0;
  logic rst_n, tick, set_b, div_run;
  logic [DW-1:0] sec, mins, hrs, a_sec, a_min, a_hr;
  logic uip, stb, alm_evt, uend;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_update_seq #(.DATA_W(DW), .LEAD_CYC(LEAD), .XFER_CYC(XFER), .HALF_CYC(HALF)) dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .set_i(set_b), .div_run_i(div_run),
    .sec_i(sec), .min_i(mins), .hr_i(hrs),
    .alm_sec_i(a_sec), .alm_min_i(a_min), .alm_hr_i(a_hr),
    .uip_o(uip), .upd_stb_o(stb), .alarm_evt_o(alm_evt), .uend_evt_o(uend)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;
  bit cmp_on  = 0;

  task automatic check_eq(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: phase number since start, -1 when idle.
  int m_phase = -1;
  int m_wait  = -1;
  bit m_armed = 0;
  bit m_prev_div = 0;
  bit e_uip = 0, e_stb = 0, e_uend = 0, e_alm = 0;

  function automatic bit fmatch(input logic [DW-1:0] al, input logic [DW-1:0] cu);
    return (al == cu) || (al[DW-1:DW-2] == 2'b11);
  endfunction

  always @(posedge clk) begin
    bit go;
    go = 0;
    e_stb = 0; e_uend = 0; e_alm = 0;
    if (!rst_n) begin
      m_phase = -1; m_wait = -1; m_armed = 0; m_prev_div = 0;
    end else begin
      if (!div_run) begin
        m_phase = -1; m_wait = -1; m_armed = 0;
      end else begin
        if (!m_prev_div) begin
          m_wait = 0; m_armed = 0;
        end else if (m_wait >= 0) begin
          if (m_wait == HALF - 1) begin
            m_wait = -1; m_armed = 1; go = !set_b;
          end else m_wait++;
        end else if (m_armed && tick && !set_b) go = 1;

        if (set_b) m_phase = -1;
        else if (m_phase >= 0) begin
          m_phase++;
          if (m_phase == LEAD) e_stb = 1;
          if (m_phase == LEAD + XFER) begin
            m_phase = -1;
            e_uend  = 1;
            e_alm   = fmatch(a_sec, sec) && fmatch(a_min, mins) && fmatch(a_hr, hrs);
          end
        end else if (go) m_phase = 0;
      end
      m_prev_div = div_run;
    end
    e_uip = (m_phase >= 0);
  end

  // Per-cycle comparison and pulse counting, away from the active edge.
  int c_uend = 0, c_alm = 0, c_stb = 0;
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      check_eq("R2 uip_o", uip, e_uip);
      check_eq("R3 upd_stb_o", stb, e_stb);
      check_eq("R4 uend_evt_o", uend, e_uend);
      check_eq("R5 alarm_evt_o", alm_evt, e_alm);
    end
    if (stb)     begin c_stb++; sec <= sec + 1'b1; end
    if (uend)    c_uend++;
    if (alm_evt) c_alm++;
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic expect_counts(input string tag, input int s0, input int u0, input int a0,
                               input int ds, input int du, input int da);
    check_eq({tag, " strobes"}, c_stb - s0, ds);
    check_eq({tag, " update-ended"}, c_uend - u0, du);
    check_eq({tag, " alarms"}, c_alm - a0, da);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int s0, u0, a0;
    rst_n = 1'b0; tick = 0; set_b = 0; div_run = 0;
    sec = 8'd0; mins = 8'd0; hrs = 8'd0;
    a_sec = 8'd59; a_min = 8'd0; a_hr = 8'd0;
    wait_n(5);
    rst_n = 1'b1;
    wait_n(4);
    // R1: reset state
    check_eq("R1 uip_o", uip, 0);
    check_eq("R1 upd_stb_o", stb, 0);
    check_eq("R1 uend_evt_o", uend, 0);
    check_eq("R1 alarm_evt_o", alm_evt, 0);
    cmp_on = 1;

    // R9: first update comes from the half-second delay; early ticks ignored
    s0 = c_stb; u0 = c_uend; a0 = c_alm;
    div_run = 1'b1;
    wait_n(2); pulse_tick();
    wait_n(5); pulse_tick();
    wait_n(60);
    expect_counts("R9 first update", s0, u0, a0, 1, 1, 0);

    // R5: alarm compared on post-update seconds (1 -> 2)
    a_sec = 8'd2;
    s0 = c_stb; u0 = c_uend; a0 = c_alm;
    pulse_tick(); wait_n(40);
    expect_counts("R5 exact alarm", s0, u0, a0, 1, 1, 1);

    // R6 and R11: wildcard bytes, alarm on every update
    a_sec = 8'hC7; a_min = 8'hFF;
    s0 = c_stb; u0 = c_uend; a0 = c_alm;
    pulse_tick(); wait_n(40);
    pulse_tick(); wait_n(40);
    expect_counts("R6 R11 wildcard recurring", s0, u0, a0, 2, 2, 2);

    // R10: extra ticks during a sequence are ignored
    s0 = c_stb; u0 = c_uend; a0 = c_alm;
    pulse_tick(); wait_n(3); pulse_tick(); wait_n(3); pulse_tick();
    wait_n(40);
    expect_counts("R10 ticks while busy", s0, u0, a0, 1, 1, 1);

    // R7: SET before the strobe aborts, and a tick during SET is ignored
    s0 = c_stb; u0 = c_uend; a0 = c_alm;
    pulse_tick(); wait_n(2);
    set_b = 1'b1;
    wait_n(30); pulse_tick(); wait_n(30);
    set_b = 1'b0;
    wait_n(5);
    expect_counts("R7 set before strobe", s0, u0, a0, 0, 0, 0);

    // R7: SET after the strobe suppresses the events
    s0 = c_stb; u0 = c_uend; a0 = c_alm;
    pulse_tick(); wait_n(8);
    set_b = 1'b1;
    wait_n(30);
    set_b = 1'b0;
    wait_n(5);
    expect_counts("R7 set after strobe", s0, u0, a0, 1, 0, 0);

    // R8: divider stop aborts; ticks ignored while stopped
    s0 = c_stb; u0 = c_uend; a0 = c_alm;
    pulse_tick(); wait_n(8);
    div_run = 1'b0;
    wait_n(10); pulse_tick(); wait_n(20);
    expect_counts("R8 divider stopped", s0, u0, a0, 1, 0, 0);

    // R9: restart after the divider resumes
    s0 = c_stb; u0 = c_uend; a0 = c_alm;
    div_run = 1'b1;
    wait_n(2); pulse_tick(); wait_n(60);
    expect_counts("R9 restart delay", s0, u0, a0, 1, 1, 1);

    // R5: exact seconds byte that does not match gives no alarm
    a_sec = 8'd0;
    s0 = c_stb; u0 = c_uend; a0 = c_alm;
    pulse_tick(); wait_n(40);
    expect_counts("R5 mismatch", s0, u0, a0, 1, 1, 0);

    finish_run();
  end

endmodule